// File: doc/BRIEF.md
# Hardware Task-Switch Sequencer

This block carries out the memory side of a hardware task switch for a segmented processor core. On a start pulse it first checks that both the outgoing and the incoming task-state segments are long enough for their layout. A segment's descriptor type selects its layout: types 0 to 3 use the 16-bit layout and all other types use the 32-bit layout. If either segment is too short, the block reports an invalid-segment fault and does nothing else.

If both checks pass, the block runs a fixed sequence of single memory accesses. It stores the live register file into the old segment. On a call or interrupt it writes the back-link. It reads the register image of the new task, with CR3 included when paging is on and the layout is 32-bit. It then updates the busy bits of the two task descriptors with read-modify-write cycles in the descriptor table. All loaded state, together with the control-register side effects, is presented in a single completion cycle.

The core must hold its register, base, limit and selector inputs stable while `busy_o` is high. The memory port takes one request at a time. Each request is held unchanged until the memory accepts it with ready.

Top module: `tsw_seq`

## Requirements
- R1: The new segment must have a limit of at least 0x2B for the 16-bit layout (type 3 or less) and at least 0x67 for the 32-bit layout. On a violation, `fault_o` and `fault_new_o` pulse in the cycle after start. No memory access is made and no held output changes. This check takes priority over R2.
- R2: The old segment must have a limit of at least 0x29 for the 16-bit layout and at least 0x5F for the 32-bit layout. On a violation, `fault_o` pulses with `fault_new_o` low. No memory access is made.
- R3: For a 32-bit old layout, the block writes 4-byte values to the old base: EIP at 0x20, EFLAGS at 0x24, and the eight general registers (index 0 to 7) at 0x28 + 4*k. It then writes 2-byte values: the six selectors (index 0 to 5) at 0x48 + 4*k.
- R4: For a 16-bit old layout, every write is 2 bytes and carries the low halves. IP goes to 14, FLAGS to 16, general register k to 18 + 2*k, and selector k (k = 0..3) to 34 + 2*k.
- R5: When `new_busy_i` is set, bit 14 (NT) is clear in the saved flags. Otherwise the flags are saved unchanged.
- R6: Only for source call/interrupt (`src_i` = 1), `old_sel_i` is written as 2 bytes to offset 0 of the new segment. A jump (`src_i` = 0) or return (`src_i` = 2) leaves that word untouched.
- R7: For a 32-bit new layout, the block reads EIP, EFLAGS, the general registers, the six selectors, the LDT selector (0x60) and the trap word (0x64) from the same offsets as R3. `cr3_load_o` pulses at completion only if paging is on and the dword at 0x1C differs from `cr3_i`.
- R8: For a 16-bit new layout, the block reads from the offsets of R4, with the LDT selector at 42. The general registers get 0xFFFF as their upper half. EIP and EFLAGS get a zero upper half. Selectors 4 and 5 become 0.
- R9: On a call/interrupt, `eflags_o` has bit 14 set. Otherwise it equals the loaded flags.
- R10: On a jump or call, bit 9 (mask 0x200) is set in the dword at table base + (new selector & 0xFFF8) + 4, and the other bits are kept.
- R11: On a jump or return, bit 9 is cleared in the dword at table base + (old selector & 0xFFF8) + 4, and the other bits are kept.
- R12: At completion, `done_o` and `cr0_ts_o` pulse and `dr7_o` equals `dr7_i` with mask 0x155 cleared. `trap_bs_o` pulses only for a 32-bit new task whose trap word has bit 0 set.
- R13: The block issues at most one access at a time and holds it stable until `mem_ready_i`. `mem_size4_o` is 1 for a 4-byte access and 0 for a 2-byte access. No access is made while idle, and the held outputs change only in the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a switch (sampled while idle) |
| src_i | input | 2 | 0 jump, 1 call/interrupt, 2 return |
| old_base_i | input | ADDR_W | Old segment base |
| old_limit_i | input | 32 | Old segment limit |
| old_type_i | input | 4 | Old descriptor type |
| new_base_i | input | ADDR_W | New segment base |
| new_limit_i | input | 32 | New segment limit |
| new_type_i | input | 4 | New descriptor type |
| new_busy_i | input | 1 | Target descriptor already busy |
| tbl_base_i | input | ADDR_W | Descriptor table base |
| old_sel_i | input | 16 | Current task selector |
| new_sel_i | input | 16 | Target task selector |
| paging_i | input | 1 | Paging enabled |
| cr3_i | input | 32 | Current page-table root |
| dr7_i | input | 32 | Current debug control |
| eip_i | input | 32 | Current instruction pointer |
| eflags_i | input | 32 | Current flags |
| gpr_i | input | 8x32 | Current general registers |
| seg_i | input | 6x16 | Current segment selectors |
| mem_req_o | output | 1 | Access request |
| mem_we_o | output | 1 | Access is a write |
| mem_size4_o | output | 1 | 1: 4 bytes, 0: 2 bytes |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Access accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Invalid-segment fault pulse |
| fault_new_o | output | 1 | Fault concerns the new segment |
| eip_o | output | 32 | Loaded instruction pointer |
| eflags_o | output | 32 | Loaded flags |
| gpr_o | output | 8x32 | Loaded general registers |
| seg_o | output | 6x16 | Loaded selectors |
| ldt_o | output | 16 | Loaded LDT selector |
| cr3_o | output | 32 | Page-table root after the switch |
| cr3_load_o | output | 1 | New page-table root pulse |
| cr0_ts_o | output | 1 | Set task-switched flag pulse |
| dr7_o | output | 32 | Debug control after the switch |
| trap_bs_o | output | 1 | Set debug-status bit 15 pulse |

## Verification
The embedded properties check on every cycle that the memory request stays quiet while idle and is held unchanged under back-pressure. They also check that a fault pulse never comes with an access or a completion, that the link write happens only on a call, that 16-bit saves never use 4-byte accesses, and that the debug-control mask is clear at completion. Only the bench scenarios can show whether the data landed at the right offsets for each mix of layouts. The same holds for the 16-bit padding on load, the source-dependent busy, link and NT rules, the exact limit boundaries, and the CR3 and trap-word decisions.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned NGPR   = 8;
  localparam int unsigned NSEG   = 6;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned OFF_W  = 8;

  localparam logic [IDX_W-1:0] SAVE_LAST_W = IDX_W'(16);
  localparam logic [IDX_W-1:0] SAVE_LAST_N = IDX_W'(14);
  localparam logic [IDX_W-1:0] LOAD_LAST_W = IDX_W'(18);
  localparam logic [IDX_W-1:0] LOAD_LAST_N = IDX_W'(15);

  localparam logic [DATA_W-1:0] BUSY_MASK = 32'h0000_0200;
  localparam logic [DATA_W-1:0] NT_MASK   = 32'h0000_4000;
  localparam logic [DATA_W-1:0] DR7_CLR   = 32'h0000_0155;

  typedef enum logic [1:0] {
    SRC_JUMP = 2'd0,
    SRC_CALL = 2'd1,
    SRC_RET  = 2'd2
  } tsw_src_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SAVE, ST_LINK, ST_LOAD,
    ST_BSET_RD, ST_BSET_WR, ST_BCLR_RD, ST_BCLR_WR, ST_COMMIT
  } tsw_state_e;

  typedef enum logic [2:0] {
    FLD_CR3, FLD_IP, FLD_FLAGS, FLD_GPR, FLD_SEL, FLD_LDT, FLD_TRAP
  } tsw_fld_e;
endpackage

// File: rtl/tsw_limit_chk.sv
module tsw_limit_chk #(
  parameter int unsigned LIM_W = 32,
  parameter int unsigned MIN_N = 'h2B,
  parameter int unsigned MIN_W = 'h67
) (
  input  logic [3:0]       type_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             wide_o,
  output logic             ok_o
);
  always_comb begin
    wide_o = (type_i > 4'd3);
    ok_o   = wide_o ? (limit_i >= LIM_W'(MIN_W)) : (limit_i >= LIM_W'(MIN_N));
  end
endmodule

// File: rtl/tsw_step_map.sv
module tsw_step_map
  import tsw_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wide_i,
  output logic [OFF_W-1:0] off_o,
  output logic             size4_o,
  output tsw_fld_e         fld_o,
  output logic [2:0]       sub_o
);
  logic [IDX_W-1:0] d_gpr, d_sel;

  always_comb begin
    d_gpr   = idx_i - IDX_W'(3);
    d_sel   = idx_i - IDX_W'(11);
    sub_o   = 3'd0;
    size4_o = 1'b0;
    fld_o   = FLD_LDT;
    if (wide_i) begin
      off_o = OFF_W'(8'h1C) + OFF_W'({idx_i, 2'b00});
      if (idx_i == '0) begin
        fld_o = FLD_CR3; size4_o = 1'b1;
      end else if (idx_i == IDX_W'(1)) begin
        fld_o = FLD_IP; size4_o = 1'b1;
      end else if (idx_i == IDX_W'(2)) begin
        fld_o = FLD_FLAGS; size4_o = 1'b1;
      end else if (idx_i <= IDX_W'(10)) begin
        fld_o = FLD_GPR; size4_o = 1'b1; sub_o = d_gpr[2:0];
      end else if (idx_i <= IDX_W'(16)) begin
        fld_o = FLD_SEL; sub_o = d_sel[2:0];
      end else if (idx_i == IDX_W'(17)) begin
        fld_o = FLD_LDT;
      end else begin
        fld_o = FLD_TRAP;
      end
    end else begin
      off_o = OFF_W'(8'd12) + OFF_W'({idx_i, 1'b0});
      if (idx_i == IDX_W'(1)) begin
        fld_o = FLD_IP;
      end else if (idx_i == IDX_W'(2)) begin
        fld_o = FLD_FLAGS;
      end else if (idx_i >= IDX_W'(3) && idx_i <= IDX_W'(10)) begin
        fld_o = FLD_GPR; sub_o = d_gpr[2:0];
      end else if (idx_i >= IDX_W'(11) && idx_i <= IDX_W'(14)) begin
        fld_o = FLD_SEL; sub_o = d_sel[2:0];
      end else begin
        fld_o = FLD_LDT;
      end
    end
  end
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [1:0]                      src_i,
  input  logic [ADDR_W-1:0]               old_base_i,
  input  logic [31:0]                     old_limit_i,
  input  logic [3:0]                      old_type_i,
  input  logic [ADDR_W-1:0]               new_base_i,
  input  logic [31:0]                     new_limit_i,
  input  logic [3:0]                      new_type_i,
  input  logic                            new_busy_i,
  input  logic [ADDR_W-1:0]               tbl_base_i,
  input  logic [SEL_W-1:0]                old_sel_i,
  input  logic [SEL_W-1:0]                new_sel_i,
  input  logic                            paging_i,
  input  logic [DATA_W-1:0]               cr3_i,
  input  logic [DATA_W-1:0]               dr7_i,
  input  logic [DATA_W-1:0]               eip_i,
  input  logic [DATA_W-1:0]               eflags_i,
  input  logic [NGPR-1:0][DATA_W-1:0]     gpr_i,
  input  logic [NSEG-1:0][SEL_W-1:0]      seg_i,
  output logic                            mem_req_o,
  output logic                            mem_we_o,
  output logic                            mem_size4_o,
  output logic [ADDR_W-1:0]               mem_addr_o,
  output logic [DATA_W-1:0]               mem_wdata_o,
  input  logic                            mem_ready_i,
  input  logic [DATA_W-1:0]               mem_rdata_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            fault_o,
  output logic                            fault_new_o,
  output logic [DATA_W-1:0]               eip_o,
  output logic [DATA_W-1:0]               eflags_o,
  output logic [NGPR-1:0][DATA_W-1:0]     gpr_o,
  output logic [NSEG-1:0][SEL_W-1:0]      seg_o,
  output logic [SEL_W-1:0]                ldt_o,
  output logic [DATA_W-1:0]               cr3_o,
  output logic                            cr3_load_o,
  output logic                            cr0_ts_o,
  output logic [DATA_W-1:0]               dr7_o,
  output logic                            trap_bs_o
);
  localparam logic [ADDR_W-1:0] DESC_HI = ADDR_W'(4);
  localparam logic [SEL_W-1:0]  IDX_MSK = 16'hFFF8;

  tsw_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             ow_q, nw_q, nb_q, pg_q;
  tsw_src_e         src_q;
  logic [DATA_W-1:0] rmw_q;

  logic [DATA_W-1:0]               s_eip, s_efl, s_cr3;
  logic [NGPR-1:0][DATA_W-1:0]     s_gpr;
  logic [NSEG-1:0][SEL_W-1:0]      s_seg;
  logic [SEL_W-1:0]                s_ldt;
  logic                            s_trap;

  logic old_wide, old_ok, new_wide, new_ok;

  tsw_limit_chk #(.LIM_W(32), .MIN_N('h29), .MIN_W('h5F)) u_old_chk (
    .type_i(old_type_i), .limit_i(old_limit_i), .wide_o(old_wide), .ok_o(old_ok));
  tsw_limit_chk #(.LIM_W(32), .MIN_N('h2B), .MIN_W('h67)) u_new_chk (
    .type_i(new_type_i), .limit_i(new_limit_i), .wide_o(new_wide), .ok_o(new_ok));

  logic [OFF_W-1:0] m_off;
  logic             m_size4;
  tsw_fld_e         m_fld;
  logic [2:0]       m_sub;
  logic             map_wide;

  assign map_wide = (state_q == ST_LOAD) ? nw_q : ow_q;

  tsw_step_map u_map (
    .idx_i(idx_q), .wide_i(map_wide), .off_o(m_off),
    .size4_o(m_size4), .fld_o(m_fld), .sub_o(m_sub));

  logic [DATA_W-1:0] save_val;
  logic [ADDR_W-1:0] new_desc, old_desc;
  logic              xfer;
  logic [IDX_W-1:0]  save_last, load_last, load_first;

  always_comb begin
    unique case (m_fld)
      FLD_IP:    save_val = eip_i;
      FLD_FLAGS: save_val = eflags_i & ~(nb_q ? NT_MASK : '0);
      FLD_GPR:   save_val = gpr_i[m_sub];
      FLD_SEL:   save_val = DATA_W'(seg_i[m_sub]);
      default:   save_val = '0;
    endcase
  end

  assign new_desc   = tbl_base_i + ADDR_W'(new_sel_i & IDX_MSK) + DESC_HI;
  assign old_desc   = tbl_base_i + ADDR_W'(old_sel_i & IDX_MSK) + DESC_HI;
  assign save_last  = ow_q ? SAVE_LAST_W : SAVE_LAST_N;
  assign load_last  = nw_q ? LOAD_LAST_W : LOAD_LAST_N;
  assign load_first = (nw_q && pg_q) ? IDX_W'(0) : IDX_W'(1);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_size4_o = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_SAVE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_size4_o = m_size4;
        mem_addr_o  = old_base_i + ADDR_W'(m_off);
        mem_wdata_o = m_size4 ? save_val : {16'h0, save_val[15:0]};
      end
      ST_LINK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = new_base_i;
        mem_wdata_o = DATA_W'(old_sel_i);
      end
      ST_LOAD: begin
        mem_req_o   = 1'b1;
        mem_size4_o = m_size4;
        mem_addr_o  = new_base_i + ADDR_W'(m_off);
      end
      ST_BSET_RD, ST_BSET_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = (state_q == ST_BSET_WR);
        mem_size4_o = 1'b1;
        mem_addr_o  = new_desc;
        mem_wdata_o = rmw_q | BUSY_MASK;
      end
      ST_BCLR_RD, ST_BCLR_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = (state_q == ST_BCLR_WR);
        mem_size4_o = 1'b1;
        mem_addr_o  = old_desc;
        mem_wdata_o = rmw_q & ~BUSY_MASK;
      end
      default: ;
    endcase
  end

  assign xfer   = mem_req_o && mem_ready_i;
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ow_q    <= 1'b0;
      nw_q    <= 1'b0;
      nb_q    <= 1'b0;
      pg_q    <= 1'b0;
      src_q   <= SRC_JUMP;
      rmw_q   <= '0;
      s_eip   <= '0;
      s_efl   <= '0;
      s_cr3   <= '0;
      s_gpr   <= '0;
      s_seg   <= '0;
      s_ldt   <= '0;
      s_trap  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i && new_ok && old_ok) begin
          state_q  <= ST_SAVE;
          idx_q    <= IDX_W'(1);
          ow_q     <= old_wide;
          nw_q     <= new_wide;
          nb_q     <= new_busy_i;
          pg_q     <= paging_i;
          src_q    <= tsw_src_e'(src_i);
          s_seg[4] <= '0;
          s_seg[5] <= '0;
          s_trap   <= 1'b0;
          s_cr3    <= cr3_i;
        end
        ST_SAVE: if (xfer) begin
          if (idx_q == save_last) begin
            state_q <= (src_q == SRC_CALL) ? ST_LINK : ST_LOAD;
            idx_q   <= load_first;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_LINK: if (xfer) state_q <= ST_LOAD;
        ST_LOAD: if (xfer) begin
          unique case (m_fld)
            FLD_CR3:   s_cr3 <= mem_rdata_i;
            FLD_IP:    s_eip <= nw_q ? mem_rdata_i : {16'h0, mem_rdata_i[15:0]};
            FLD_FLAGS: s_efl <= nw_q ? mem_rdata_i : {16'h0, mem_rdata_i[15:0]};
            FLD_GPR:   s_gpr[m_sub] <= nw_q ? mem_rdata_i : {16'hFFFF, mem_rdata_i[15:0]};
            FLD_SEL:   s_seg[m_sub] <= mem_rdata_i[15:0];
            FLD_LDT:   s_ldt <= mem_rdata_i[15:0];
            FLD_TRAP:  s_trap <= mem_rdata_i[0];
            default: ;
          endcase
          if (idx_q == load_last)
            state_q <= (src_q == SRC_RET) ? ST_BCLR_RD : ST_BSET_RD;
          else
            idx_q <= idx_q + IDX_W'(1);
        end
        ST_BSET_RD: if (xfer) begin rmw_q <= mem_rdata_i; state_q <= ST_BSET_WR; end
        ST_BSET_WR: if (xfer) state_q <= (src_q == SRC_JUMP) ? ST_BCLR_RD : ST_COMMIT;
        ST_BCLR_RD: if (xfer) begin rmw_q <= mem_rdata_i; state_q <= ST_BCLR_WR; end
        ST_BCLR_WR: if (xfer) state_q <= ST_COMMIT;
        ST_COMMIT:  state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  // All architectural results change together in the completion cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      fault_new_o <= 1'b0;
      cr0_ts_o    <= 1'b0;
      cr3_load_o  <= 1'b0;
      trap_bs_o   <= 1'b0;
      eip_o       <= '0;
      eflags_o    <= '0;
      gpr_o       <= '0;
      seg_o       <= '0;
      ldt_o       <= '0;
      cr3_o       <= '0;
      dr7_o       <= '0;
    end else begin
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      fault_new_o <= 1'b0;
      cr0_ts_o    <= 1'b0;
      cr3_load_o  <= 1'b0;
      trap_bs_o   <= 1'b0;
      if (state_q == ST_IDLE && start_i && !(new_ok && old_ok)) begin
        fault_o     <= 1'b1;
        fault_new_o <= !new_ok;
      end
      if (state_q == ST_COMMIT) begin
        done_o     <= 1'b1;
        cr0_ts_o   <= 1'b1;
        eip_o      <= s_eip;
        eflags_o   <= s_efl | ((src_q == SRC_CALL) ? NT_MASK : '0);
        gpr_o      <= s_gpr;
        seg_o      <= s_seg;
        ldt_o      <= s_ldt;
        cr3_o      <= s_cr3;
        cr3_load_o <= nw_q && pg_q && (s_cr3 != cr3_i);
        trap_bs_o  <= nw_q && s_trap;
        dr7_o      <= dr7_i & ~DR7_CLR;
      end
    end
  end

  a_r13_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  a_r13_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o) && $stable(mem_size4_o)));
  a_r1_fault_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!mem_req_o && !done_o));
  a_r6_link_only_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LINK) |-> (src_q == SRC_CALL));
  a_r4_narrow_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAVE && !ow_q) |-> !mem_size4_o);
  a_r12_dr7_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((dr7_o & DR7_CLR) == '0));
endmodule

// File: tb/tsw_seq_tb.sv
module tsw_seq_tb_top;
  import tsw_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OB = 32'h200;
  localparam logic [31:0] NB = 32'h400;
  localparam logic [31:0] TB = 32'h800;
  localparam logic [15:0] OSEL = 16'h0018;
  localparam logic [15:0] NSEL = 16'h0021;
  localparam logic [31:0] ODESC = 32'h81C;
  localparam logic [31:0] NDESC = 32'h824;

  typedef struct packed {
    logic [1:0] src;
    logic ow, nw, nb, pg, c3s, tr;
    logic [7:0] ol, nl;
    logic ef, efn;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    vec_t'({2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5F, 8'h67, 1'b0, 1'b0}),
    vec_t'({2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h70, 8'h80, 1'b0, 1'b0}),
    vec_t'({2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h67, 8'h67, 1'b0, 1'b0}),
    vec_t'({2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2B, 8'h2B, 1'b0, 1'b0}),
    vec_t'({2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h29, 8'h67, 1'b0, 1'b0}),
    vec_t'({2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h5F, 8'h2B, 1'b0, 1'b0}),
    vec_t'({2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2C, 8'h67, 1'b0, 1'b0}),
    vec_t'({2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h67, 8'h66, 1'b1, 1'b1}),
    vec_t'({2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h67, 8'h2A, 1'b1, 1'b1}),
    vec_t'({2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5E, 8'h67, 1'b1, 1'b0}),
    vec_t'({2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h28, 8'h67, 1'b1, 1'b0}),
    vec_t'({2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h28, 8'h66, 1'b1, 1'b1}),
    vec_t'({2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h29, 8'h2B, 1'b0, 1'b0})
  };

  logic clk, rst_n, start;
  logic [1:0] src;
  logic [31:0] old_limit, new_limit;
  logic [3:0]  old_type, new_type;
  logic new_busy, paging, stall;
  logic [31:0] cr3_in, dr7_in, eip_in, efl_in;
  logic [NGPR-1:0][31:0] gpr_in;
  logic [NSEG-1:0][15:0] seg_in;
  logic mem_req, mem_we, mem_size4, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic busy, done, fault, fault_new, cr3_load, cr0_ts, trap_bs;
  logic [31:0] eip_out, efl_out, cr3_out, dr7_out;
  logic [NGPR-1:0][31:0] gpr_out;
  logic [NSEG-1:0][15:0] seg_out;
  logic [15:0] ldt_out;

  logic [7:0] mem [0:4095];
  int cyc, acc_cnt, checks, errors;

  tsw_seq #(.ADDR_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_i(src),
    .old_base_i(OB), .old_limit_i(old_limit), .old_type_i(old_type),
    .new_base_i(NB), .new_limit_i(new_limit), .new_type_i(new_type),
    .new_busy_i(new_busy), .tbl_base_i(TB), .old_sel_i(OSEL), .new_sel_i(NSEL),
    .paging_i(paging), .cr3_i(cr3_in), .dr7_i(dr7_in), .eip_i(eip_in),
    .eflags_i(efl_in), .gpr_i(gpr_in), .seg_i(seg_in),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size4_o(mem_size4),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fault_o(fault),
    .fault_new_o(fault_new), .eip_o(eip_out), .eflags_o(efl_out), .gpr_o(gpr_out),
    .seg_o(seg_out), .ldt_o(ldt_out), .cr3_o(cr3_out), .cr3_load_o(cr3_load),
    .cr0_ts_o(cr0_ts), .dr7_o(dr7_out), .trap_bs_o(trap_bs));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: decides ready away from the active edge.
  always @(negedge clk) begin
    logic [11:0] a;
    cyc = cyc + 1;
    a = mem_addr[11:0];
    if (mem_req && !stall && (cyc % 3) != 0) begin
      mem_ready = 1'b1;
      mem_rdata = {mem[a+12'd3], mem[a+12'd2], mem[a+12'd1], mem[a]};
      if (mem_we) begin
        mem[a] = mem_wdata[7:0];
        mem[a+12'd1] = mem_wdata[15:8];
        if (mem_size4) begin
          mem[a+12'd2] = mem_wdata[23:16];
          mem[a+12'd3] = mem_wdata[31:24];
        end
      end
      acc_cnt = acc_cnt + 1;
    end else begin
      mem_ready = 1'b0;
    end
  end

  function automatic logic [15:0] rd16(input logic [31:0] ad);
    return {mem[ad[11:0]+12'd1], mem[ad[11:0]]};
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] ad);
    return {rd16(ad + 32'd2), rd16(ad)};
  endfunction
  task automatic wr32(input logic [31:0] ad, input logic [31:0] v);
    mem[ad[11:0]] = v[7:0];          mem[ad[11:0]+12'd1] = v[15:8];
    mem[ad[11:0]+12'd2] = v[23:16];  mem[ad[11:0]+12'd3] = v[31:24];
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_case(input int c, input vec_t v, input int stall_cyc);
    logic [31:0] nt, lnk0, od0, nd0, eip_prev, fl_exp;
    int acc0, t;
    bit is_call;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 13 + c * 5 + 1);
    wr32(ODESC, 32'h0000_8B00);
    wr32(NDESC, v.nb ? 32'h0000_8B00 : 32'h0000_8900);
    cr3_in = 32'h0012_3000 + 32'(c);
    if (v.nw && v.pg) wr32(NB + 32'h1C, v.c3s ? cr3_in : cr3_in + 32'h1000);
    if (v.nw) wr32(NB + 32'h64, v.tr ? 32'h0000_0001 : 32'h0000_0000);
    src = v.src; is_call = (v.src == 2'd1);
    old_type = v.ow ? 4'hB : 4'h3;
    new_type = v.nw ? (v.nb ? 4'hB : 4'h9) : (v.nb ? 4'h3 : 4'h1);
    old_limit = 32'(v.ol); new_limit = 32'(v.nl);
    new_busy = v.nb; paging = v.pg;
    dr7_in = 32'hFFFF_0FFF ^ 32'(c);
    eip_in = 32'hA000_0000 + 32'(c * 32'h111);
    efl_in = 32'h0025_4202 | 32'(c << 6);
    for (int k = 0; k < NGPR; k++) gpr_in[k] = {8'(c), 8'(k), 16'h1357 + 16'(k * 9)};
    for (int k = 0; k < NSEG; k++) seg_in[k] = 16'h0100 * 16'(k) + 16'(c) + 16'h8;
    lnk0 = 32'(rd16(NB)); od0 = rd32(ODESC); nd0 = rd32(NDESC);
    eip_prev = eip_out; acc0 = acc_cnt;
    stall = (stall_cyc > 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (stall_cyc > 0) begin
      repeat (stall_cyc) @(negedge clk);
      chk("R13 request held under stall", {31'b0, mem_req}, 32'd1);
      chk("R13 no transfer under stall", 32'(acc_cnt - acc0), 32'd0);
      chk("R13 no early completion", {31'b0, done}, 32'd0);
      stall = 1'b0;
    end
    t = 0;
    while (!done && !fault && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk("R13 switch finishes", 32'd0, 32'd1);
    chk("R1 R2 fault pulse", {31'b0, fault}, {31'b0, v.ef});
    if (v.ef) begin
      chk("R1 R2 fault side", {31'b0, fault_new}, {31'b0, v.efn});
      chk("R1 R2 no access on fault", 32'(acc_cnt - acc0), 32'd0);
      chk("R1 outputs unchanged on fault", eip_out, eip_prev);
      chk("R2 old descriptor unchanged", rd32(ODESC), od0);
      @(negedge clk);
      chk("R13 idle after fault", {31'b0, busy}, 32'd0);
      return;
    end
    chk("R12 done pulse", {31'b0, done}, 32'd1);
    chk("R12 cr0 ts pulse", {31'b0, cr0_ts}, 32'd1);
    chk("R12 dr7 masked", dr7_out, dr7_in & ~32'h155);
    chk("R12 trap status", {31'b0, trap_bs}, {31'b0, v.nw & v.tr});
    nt = v.nb ? 32'h4000 : 32'h0;
    if (v.ow) begin
      chk("R3 saved eip", rd32(OB + 32'h20), eip_in);
      chk("R5 R3 saved flags", rd32(OB + 32'h24), efl_in & ~nt);
      for (int k = 0; k < NGPR; k++) chk("R3 saved gpr", rd32(OB + 32'h28 + 32'(4*k)), gpr_in[k]);
      for (int k = 0; k < NSEG; k++) chk("R3 saved selector", 32'(rd16(OB + 32'h48 + 32'(4*k))), 32'(seg_in[k]));
    end else begin
      chk("R4 saved ip", 32'(rd16(OB + 32'd14)), 32'(eip_in[15:0]));
      chk("R5 R4 saved flags", 32'(rd16(OB + 32'd16)), 32'(efl_in[15:0] & ~nt[15:0]));
      chk("R4 no spill past flags", 32'(rd16(OB + 32'd18)), 32'(gpr_in[0][15:0]));
      for (int k = 0; k < NGPR; k++) chk("R4 saved gpr", 32'(rd16(OB + 32'd18 + 32'(2*k))), 32'(gpr_in[k][15:0]));
      for (int k = 0; k < 4; k++) chk("R4 saved selector", 32'(rd16(OB + 32'd34 + 32'(2*k))), 32'(seg_in[k]));
    end
    chk("R6 link word", 32'(rd16(NB)), is_call ? 32'(OSEL) : lnk0);
    if (v.nw) begin
      fl_exp = rd32(NB + 32'h24);
      chk("R7 loaded eip", eip_out, rd32(NB + 32'h20));
      for (int k = 0; k < NGPR; k++) chk("R7 loaded gpr", gpr_out[k], rd32(NB + 32'h28 + 32'(4*k)));
      for (int k = 0; k < NSEG; k++) chk("R7 loaded selector", 32'(seg_out[k]), 32'(rd16(NB + 32'h48 + 32'(4*k))));
      chk("R7 loaded ldt", 32'(ldt_out), 32'(rd16(NB + 32'h60)));
      chk("R7 cr3 reload", {31'b0, cr3_load}, {31'b0, v.pg & ~v.c3s});
      if (v.pg && !v.c3s) chk("R7 cr3 value", cr3_out, cr3_in + 32'h1000);
    end else begin
      fl_exp = {16'h0, rd16(NB + 32'd16)};
      chk("R8 loaded ip padded", eip_out, {16'h0, rd16(NB + 32'd14)});
      for (int k = 0; k < NGPR; k++) chk("R8 loaded gpr padded", gpr_out[k], {16'hFFFF, rd16(NB + 32'd18 + 32'(2*k))});
      for (int k = 0; k < 4; k++) chk("R8 loaded selector", 32'(seg_out[k]), 32'(rd16(NB + 32'd34 + 32'(2*k))));
      chk("R8 fs null", 32'(seg_out[4]), 32'd0);
      chk("R8 gs null", 32'(seg_out[5]), 32'd0);
      chk("R8 loaded ldt", 32'(ldt_out), 32'(rd16(NB + 32'd42)));
      chk("R8 no cr3 reload", {31'b0, cr3_load}, 32'd0);
    end
    chk("R9 loaded flags", efl_out, fl_exp | (is_call ? 32'h4000 : 32'h0));
    chk("R10 new busy bit", rd32(NDESC), (v.src != 2'd2) ? (nd0 | 32'h200) : nd0);
    chk("R11 old busy bit", rd32(ODESC), (v.src != 2'd1) ? (od0 & ~32'h200) : od0);
    @(negedge clk);
    chk("R12 done is a pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors = errors + 1;
    $display("FAIL R13 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc = 0; acc_cnt = 0; checks = 0; errors = 0;
    rst_n = 1'b0; start = 1'b0; stall = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
    src = '0; old_limit = '0; new_limit = '0; old_type = '0; new_type = '0;
    new_busy = 1'b0; paging = 1'b0; cr3_in = '0; dr7_in = '0; eip_in = '0;
    efl_in = '0; gpr_in = '0; seg_in = '0;
    repeat (3) @(negedge clk);
    chk("R13 reset busy", {31'b0, busy}, 32'd0);
    chk("R13 reset no request", {31'b0, mem_req}, 32'd0);
    chk("R12 reset no done", {31'b0, done}, 32'd0);
    chk("R1 reset no fault", {31'b0, fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle without start", {31'b0, mem_req}, 32'd0);
    for (int c = 0; c < NV; c++) run_case(c, VECS[c], 0);
    // Directed: long back-pressure during a mixed-width call.
    run_case(20, VECS[6], 25);
    // Directed: exact boundary limits on the 32-bit layout after a narrow run.
    run_case(21, vec_t'({2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5F, 8'h67, 1'b0, 1'b0}), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule